// File: doc/BRIEF.md
# Interleaved Channel Offset Canceller

This block sits directly after a four-way time-interleaved ADC. It takes the single multiplexed sample stream and treats each interleave phase as its own sub-converter, whose DC offset differs from the others. The input is assumed to carry no DC of its own. Under that assumption the long-run average of each phase equals that phase's offset. The block gathers a block of N samples per phase, takes their mean as that phase's offset estimate, and subtracts the current estimate from every sample of that phase. Gain and timing correction come later in the chain and are kept separate.

Every accepted sample carries a phase tag. The tag comes either from the `in_phase` input or, when a parameter selects it, from an internal counter that steps modulo four on each valid sample. The corrected sample leaves one cycle later with its valid and phase tag. The four live estimates are also driven out so that later stages can see them. The default block size is 16 samples per phase, so a round-robin stream has all four estimates in place after 64 samples.

Top module: `ofs_canceller`

## Requirements
- R1: After a synchronous active-low reset, all four offset estimates are zero and `out_valid` is low.
- R2: `out_valid` follows `in_valid` with a latency of exactly one cycle. `out_phase` carries the phase of the same sample (phase p means channel p, p in 0..3).
- R3: Each output sample equals the input sample minus its own channel's estimate as it stood before that sample arrived.
- R4: A channel's estimate changes only when its block of N samples completes. It then becomes the floor of the block sum divided by N, rounding toward minus infinity. Until then the previous estimate stays in force.
- R5: A sample tagged with phase p touches only the accumulator and estimate of channel p.
- R6: The corrected output saturates to the signed input range, −2^(W−1) to 2^(W−1)−1, with W = 12 by default.
- R7: The accumulators cannot overflow. A block of N full-scale samples, either all −2048 or all +2047, gives that same value as the estimate.
- R8: Cycles with `in_valid` low change neither the estimates nor the position within any block.
- R9: With a round-robin stream whose signal averages to zero, all four estimates equal the channel offsets after 4·N samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 12 | Signed raw sample |
| in_phase | input | 2 | Channel index of the sample (unused when the internal counter is selected) |
| out_valid | output | 1 | Corrected sample strobe |
| out_data | output | 12 | Signed offset-corrected sample |
| out_phase | output | 2 | Channel index of the corrected sample |
| ofs_est | output | 48 | Four signed 12-bit estimates, channel i in bits [12i+11:12i] |

## Verification
The assertions assume that `in_phase` is a legal channel index whenever `in_valid` is high. They also assume that the stream carries no X values on valid cycles. The stimulus obeys both: it drives only phases 0..3, it always drives defined data, and it mixes round-robin runs, idle gaps and long runs on a single channel. The saturation property relies only on the signs of the sample and the selected estimate. Full-scale blocks are therefore used deliberately to push the subtraction past both rails.

// File: rtl/ofs_pkg.sv
// Package: ofs_pkg
// Shared definitions for the interleaved offset canceller.
// Assumes nothing beyond IEEE 1800-2017 synthesis semantics.
package ofs_pkg;

    // Where the per-sample channel tag comes from.
    typedef enum logic {
        PH_EXTERNAL = 1'b0,
        PH_INTERNAL = 1'b1
    } phase_src_e;

endpackage

// File: rtl/ofs_phase_src.sv
// Module: ofs_phase_src
// Produces the channel tag of the sample currently on the input. The tag is
// either passed through from the port, or generated by a modulo-NUM_CH
// counter that advances on every valid sample.
// Assumes NUM_CH fits in PH_W bits.
module ofs_phase_src
    import ofs_pkg::*;
#(
    parameter int         NUM_CH = 4,
    parameter int         PH_W   = 2,
    parameter phase_src_e SRC    = PH_EXTERNAL
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [PH_W-1:0] in_phase,
    output logic [PH_W-1:0] phase
);

    localparam logic [PH_W-1:0] LAST_PH = PH_W'(NUM_CH - 1);

    generate
        if (SRC == PH_INTERNAL) begin : g_internal
            logic [PH_W-1:0] ph_q;
            logic            unused_ext;

            // Step the round-robin phase on each accepted sample.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ph_q <= '0;
                else if (in_valid)
                    ph_q <= (ph_q == LAST_PH) ? '0 : ph_q + 1'b1;
            end

            assign phase      = ph_q;
            assign unused_ext = ^in_phase;
        end else begin : g_external
            logic unused_ctl;

            assign phase      = in_phase;
            assign unused_ctl = clk ^ rst_n ^ in_valid;
        end
    endgenerate

endmodule

// File: rtl/ofs_chan_acc.sv
// Module: ofs_chan_acc
// Per-channel block averager. It sums 2**LOG2_N samples of one channel and,
// on the last one, loads the floor mean into the estimate and clears the sum.
// Assumes the accumulator is DATA_W+LOG2_N bits wide, so a full block of
// full-scale samples cannot overflow.
module ofs_chan_acc #(
    parameter int DATA_W = 12,
    parameter int LOG2_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [DATA_W-1:0] sample,
    output logic [DATA_W-1:0] est
);

    localparam int ACC_W = DATA_W + LOG2_N;

    logic signed [ACC_W-1:0]  acc_q;
    logic        [LOG2_N-1:0] cnt_q;
    logic signed [ACC_W-1:0]  sum_next;
    logic                     last;

    // Running sum including the present sample, and the block-end flag.
    always_comb begin
        sum_next = acc_q + ACC_W'($signed(sample));
        last     = (cnt_q == '1);
    end

    // Accumulate, and at block end publish the mean and start a new block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
            est   <= '0;
        end else if (hit) begin
            cnt_q <= cnt_q + 1'b1;
            if (last) begin
                acc_q <= '0;
                est   <= DATA_W'(sum_next >>> LOG2_N);
            end else begin
                acc_q <= sum_next;
            end
        end
    end

    // R5: samples of other channels leave this estimate alone.
    assert_other_chan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(est) && $stable(cnt_q));

    // R4: inside a block the previous estimate stays in force.
    assert_hold_mid_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !last) |=> $stable(est));

endmodule

// File: rtl/ofs_sub_sat.sv
// Module: ofs_sub_sat
// Output stage: subtracts the channel estimate from the sample, clips the
// result to DATA_W signed bits and registers it with its valid and tag.
// Assumes both operands are two's complement of DATA_W bits.
module ofs_sub_sat #(
    parameter int DATA_W = 12,
    parameter int PH_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] est_sel,
    input  logic [PH_W-1:0]   phase,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [PH_W-1:0]   out_phase
);

    localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_MAX = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [DATA_W:0]   diff;
    logic        [DATA_W-1:0] clipped;

    // One extra bit of headroom, then clip on sign disagreement.
    always_comb begin
        diff = (DATA_W+1)'($signed(sample)) - (DATA_W+1)'($signed(est_sel));
        if (diff[DATA_W] != diff[DATA_W-1])
            clipped = diff[DATA_W] ? NEG_MAX : POS_MAX;
        else
            clipped = diff[DATA_W-1:0];
    end

    // Register the corrected sample; valid is the only reset-critical bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_phase <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data  <= clipped;
                out_phase <= phase;
            end
        end
    end

endmodule

// File: rtl/ofs_canceller.sv
// Module: ofs_canceller
// Background DC-offset canceller for a time-interleaved ADC stream. Each
// interleave phase has its own block averager. Every sample is corrected
// with its channel's current estimate and leaves one cycle later.
// Assumes the input carries no DC of its own and that in_phase < NUM_CH
// whenever in_valid is high.
module ofs_canceller
    import ofs_pkg::*;
#(
    parameter int         DATA_W    = 12,
    parameter int         NUM_CH    = 4,
    parameter int         LOG2_N    = 4,
    parameter phase_src_e PHASE_SRC = PH_EXTERNAL,
    localparam int        PH_W      = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [DATA_W-1:0]        in_data,
    input  logic [PH_W-1:0]          in_phase,
    output logic                     out_valid,
    output logic [DATA_W-1:0]        out_data,
    output logic [PH_W-1:0]          out_phase,
    output logic [NUM_CH*DATA_W-1:0] ofs_est
);

    logic [PH_W-1:0]   cur_phase;
    logic [DATA_W-1:0] est_q [NUM_CH];
    logic [DATA_W-1:0] est_sel;

    // Tag source for the current sample.
    ofs_phase_src #(.NUM_CH(NUM_CH), .PH_W(PH_W), .SRC(PHASE_SRC)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_phase (in_phase),
        .phase    (cur_phase)
    );

    // One averager per interleave phase.
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
            logic hit;
            assign hit = in_valid && (cur_phase == PH_W'(c));

            ofs_chan_acc #(.DATA_W(DATA_W), .LOG2_N(LOG2_N)) u_acc (
                .clk    (clk),
                .rst_n  (rst_n),
                .hit    (hit),
                .sample (in_data),
                .est    (est_q[c])
            );

            assign ofs_est[c*DATA_W +: DATA_W] = est_q[c];
        end
    endgenerate

    // Pick the estimate that belongs to the present sample.
    assign est_sel = est_q[cur_phase];

    // Subtract, clip and register.
    ofs_sub_sat #(.DATA_W(DATA_W), .PH_W(PH_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .sample    (in_data),
        .est_sel   (est_sel),
        .phase     (cur_phase),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_phase (out_phase)
    );

    // R1: reset clears the estimates and the output strobe.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && ofs_est == '0));

    // R2: one-cycle latency in both directions, and the tag travels along.
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_tag_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_phase == $past(cur_phase));

    // R8: idle cycles leave every estimate untouched.
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(ofs_est));

    // R6: subtracting a non-positive estimate never lowers a non-negative sample.
    assert_sat_direction_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_data[DATA_W-1] && (est_sel[DATA_W-1] || est_sel == '0))
        |=> $signed(out_data) >= $signed($past(in_data)));

endmodule

// File: tb/tb_ofs_canceller.sv
`timescale 1ns/1ps
module tb_ofs_canceller;

    localparam int W  = 12;
    localparam int NC = 4;
    localparam int N  = 16;

    typedef struct {
        int    d;
        int    p;
        int    e [NC];
        string tag;
    } item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [W-1:0]    in_data = '0;
    logic [1:0]      in_phase = '0;
    logic            out_valid;
    logic [W-1:0]    out_data;
    logic [1:0]      out_phase;
    logic [NC*W-1:0] ofs_est;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    item_t exp_q[$];
    int    est_m [NC];
    longint acc_m [NC];
    int    cnt_m [NC];

    always #2 clk = ~clk;

    ofs_canceller dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_phase(in_phase), .out_valid(out_valid), .out_data(out_data),
        .out_phase(out_phase), .ofs_est(ofs_est)
    );

    function automatic int est_of(int c);
        return int'($signed(ofs_est[c*W +: W]));
    endfunction

    function automatic int floor_div(longint s);
        if (s >= 0) return int'(s / N);
        return -int'((-s + N - 1) / N);
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Driver: present one sample and push its expected result.
    task automatic send(int d, int p, string tag);
        item_t it;
        int    r;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = W'(d);
        in_phase = 2'(p);
        r = d - est_m[p];
        if (r > 2047)  r = 2047;
        if (r < -2048) r = -2048;
        acc_m[p] += d;
        cnt_m[p]++;
        if (cnt_m[p] == N) begin
            est_m[p] = floor_div(acc_m[p]);
            acc_m[p] = 0;
            cnt_m[p] = 0;
        end
        it.d = r; it.p = p; it.e = est_m; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = W'(12'h5A5);
        end
    endtask

    task automatic chk_est(int c, int expv, string tag);
        check(est_of(c) == expv, tag, $sformatf("estimate ch%0d", c), est_of(c), expv);
    endtask

    // Monitor: compare each output with the head of the queue.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected out_valid", 1, 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check(int'($signed(out_data)) == it.d, it.tag, "out_data",
                          int'($signed(out_data)), it.d);
                    check(int'(out_phase) == it.p, "R2", "out_phase",
                          int'(out_phase), it.p);
                    for (int c = 0; c < NC; c++)
                        check(est_of(c) == it.e[c], "R4",
                              $sformatf("tracked estimate ch%0d", c), est_of(c), it.e[c]);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R2", "watchdog expired", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int off_a [NC] = '{5, -7, 100, -300};
        int off_b [NC] = '{-12, 33, 0, 7};
        for (int c = 0; c < NC; c++) begin
            est_m[c] = 0; acc_m[c] = 0; cnt_m[c] = 0;
        end
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        for (int c = 0; c < NC; c++) chk_est(c, 0, "R1");

        // Round-robin, zero-mean tone on top of fixed offsets.
        for (int k = 0; k < 4 * N; k++)
            send(off_a[k % 4] + (((k / 4) % 2) ? -40 : 40), k % 4, "R3");
        idle(1);
        for (int c = 0; c < NC; c++) chk_est(c, off_a[c], "R9");
        for (int k = 0; k < 4 * N; k++)
            send(off_a[k % 4] + (((k / 4) % 2) ? -40 : 40), k % 4, "R3");

        // Same pattern with idle gaps between samples.
        for (int k = 0; k < 4 * N; k++) begin
            send(off_b[k % 4] + (((k / 4) % 2) ? 100 : -100), k % 4, "R8");
            if (k % 3 == 2) idle(2);
            if (k == 30) begin
                idle(6);
                for (int c = 0; c < NC; c++) chk_est(c, est_m[c], "R8");
            end
        end
        idle(1);
        for (int c = 0; c < NC; c++) chk_est(c, off_b[c], "R9");

        // A whole block on a single channel.
        for (int k = 0; k < N; k++) send(500, 2, "R5");
        idle(1);
        chk_est(2, 500, "R5");
        chk_est(0, off_b[0], "R5");
        chk_est(1, off_b[1], "R5");
        chk_est(3, off_b[3], "R5");

        // Full-scale blocks, then saturation against them.
        for (int k = 0; k < N; k++) send(-2048, 0, "R7");
        for (int k = 0; k < N; k++) send(2047, 1, "R7");
        idle(1);
        chk_est(0, -2048, "R7");
        chk_est(1, 2047, "R7");
        send(2047, 0, "R6");
        send(-2048, 1, "R6");
        send(-1000, 1, "R6");
        for (int k = 0; k < N - 1; k++) send(0, 0, "R4");
        idle(1);
        chk_est(0, 127, "R4");

        // Floor rounding of a small negative sum.
        for (int k = 0; k < N - 1; k++) send(0, 3, "R4");
        send(-1, 3, "R4");
        idle(1);
        chk_est(3, -1, "R4");

        idle(4);
        check(exp_q.size() == 0, "R2", "outputs left pending", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule